// File: doc/BRIEF.md
# Per-Port Class Queue Scheduler

This block holds the transmit queues of a small switch. Every output port owns a set of class queues: the ordinary ports have two classes each, and the special ports (the highest-numbered ports, used for management and host traffic) have four. Each class queue is one logical queue built from two parts. Unicast frame handles are threaded onto a linked list kept in a next-pointer RAM indexed by handle. Multicast handles are copied into a small physical FIFO for that port and class. Every entry carries an 8-bit arrival stamp.

When a port can take its next frame, it raises a one-cycle ready pulse with its port number. The block serves that port's highest non-empty class. Within that class it serves the older of the two head entries, judged by wraparound-safe stamp subtraction; on equal stamps the unicast head goes first. One cycle later it reports the chosen handle, or an empty flag if the port had nothing queued.

A multicast enqueue names all of its destination ports at once, and the block records how many copies are outstanding. A release pulse tells the owner of the frame buffer that a handle may be freed. For a unicast handle the pulse comes as soon as the handle is dequeued. For a multicast handle it comes only when the last copy leaves.

The enqueue side is a valid/ready stream. `enq_ready` is computed from the presented payload alone. An enqueue is taken on a clock edge where `enq_valid` and `enq_ready` are both high. While `enq_ready` is low, the source must hold its request or withdraw it, and nothing is written. The result side has no back-pressure, because a port only pulses ready when it can accept a frame.

Top module: `csq_sched`

## Requirements
- R1: After reset, every queue is empty, `out_valid`, `out_empty` and `rel_valid` are low, and an idle enqueue port shows `enq_ready` high.
- R2: Unicast handles enqueued to one port and class leave that queue in the order they were accepted.
- R3: A multicast enqueue places the handle in the queue of every port whose bit is set in `enq_dest`. The duplicate count starts at the number of set bits. `rel_valid` pulses with that handle only together with the result that sends its last copy.
- R4: Within one class, when both the unicast head and the multicast head are present, the older one is served. A head counts as older when (multicast stamp − unicast stamp) mod 256, read as a signed 8-bit value, is positive; the unicast head is taken when that value is zero or positive. A unicast stamp of 250 is therefore older than a multicast stamp of 3.
- R5: Classes of a port are served by strict priority: the non-empty class with the largest index goes first.
- R6: Ports below `N_PORTS-N_SPECIAL` have classes 0..1 and the other ports have classes 0..3. An enqueue whose class exceeds a port's top class is placed in that top class, and results from ordinary ports never report a class above 1.
- R7: A ready pulse for a port that holds no entry gives `out_empty` high and `out_valid` low in the following cycle. `out_valid` and `out_empty` are never high together.
- R8: `enq_ready` is low for a multicast request when the multicast FIFO of any targeted port and class already holds `MC_DEPTH` entries. A request not accepted writes nothing. A unicast request is always ready.
- R9: Each ready pulse gives exactly one result cycle (`out_valid` or `out_empty`) on the following cycle, and no result appears without a pulse.
- R10: An enqueue and a dequeue on the same unicast queue in the same cycle both take effect. This includes a queue holding a single entry, where the old entry leaves and the new one becomes the head.
- R11: A unicast result raises `rel_valid` with `rel_handle` equal to `out_handle` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | Enqueue can be taken this cycle |
| enq_dest | input | N_PORTS | Destination port mask (exactly one bit for unicast) |
| enq_cls | input | CLS_W | Requested class |
| enq_handle | input | HANDLE_W | Frame handle |
| enq_mcast | input | 1 | 1 = multicast, 0 = unicast |
| enq_ts | input | TS_W | Arrival stamp |
| txr_valid | input | 1 | Port ready pulse |
| txr_port | input | PW | Port that is ready |
| out_valid | output | 1 | A handle was chosen |
| out_empty | output | 1 | The ready port had nothing queued |
| out_handle | output | HANDLE_W | Chosen handle |
| out_cls | output | CLS_W | Class the handle came from |
| out_mcast | output | 1 | Chosen handle came from the multicast FIFO |
| rel_valid | output | 1 | Handle may be freed |
| rel_handle | output | HANDLE_W | Handle being freed |

## Verification
The enqueue path and the dequeue path can act on the same queue in one clock cycle. The hardest case is a unicast list holding a single handle: the tail link is being written while the head is being advanced. The bench drives a unicast enqueue and a ready pulse for that same port and class on one edge. It then expects the old handle in the result, the new handle on the next pull and an empty flag after that, which shows that the head was taken from the incoming handle and not from a stale link.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic {
    SRC_UC = 1'b0,
    SRC_MC = 1'b1
  } csq_src_e;

  // number of classes a port owns: the top n_special ports get the wide set
  function automatic int cls_limit(input int p, input int n_ports,
                                   input int n_special, input int base_cls,
                                   input int spec_cls);
    return (p >= n_ports - n_special) ? spec_cls : base_cls;
  endfunction

endpackage

// File: rtl/csq_mc_fifo.sv
module csq_mc_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] v);
    return (int'(v) == DEPTH - 1) ? '0 : v + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (int'(cnt) == DEPTH);
  assign empty = (cnt == '0);

endmodule

// File: rtl/csq_uc_ctl.sv
module csq_uc_ctl #(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic [HW-1:0] enq_h,
  input  logic          deq,
  input  logic [HW-1:0] deq_next,
  output logic [HW-1:0] head,
  output logic [HW-1:0] tail,
  output logic          nonempty
);
  localparam int CW = HW + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      unique case ({enq, deq})
        2'b11: begin
          // single entry leaves while a new one arrives: new one is the head
          head <= (cnt == CW'(1)) ? enq_h : deq_next;
          tail <= enq_h;
        end
        2'b10: begin
          if (cnt == '0) head <= enq_h;
          tail <= enq_h;
          cnt  <= cnt + CW'(1);
        end
        2'b01: begin
          head <= deq_next;
          cnt  <= cnt - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign nonempty = (cnt != '0);

endmodule

// File: rtl/csq_pick.sv
module csq_pick
  import csq_pkg::*;
#(
  parameter int NCLS = 4,
  parameter int TS_W = 8,
  parameter int CLS_W = 2
) (
  input  logic [NCLS-1:0]           uc_ne,
  input  logic [NCLS-1:0]           mc_ne,
  input  logic [NCLS-1:0][TS_W-1:0] uc_ts,
  input  logic [NCLS-1:0][TS_W-1:0] mc_ts,
  output logic                      hit,
  output logic [CLS_W-1:0]          cls,
  output csq_src_e                  src
);
  logic [NCLS-1:0][TS_W-1:0] gap;
  logic [NCLS-1:0]           uc_first;

  // signed distance from unicast head to multicast head; >= 0 means unicast is older or tied
  for (genvar c = 0; c < NCLS; c++) begin : g_age
    assign gap[c]      = mc_ts[c] - uc_ts[c];
    assign uc_first[c] = ~gap[c][TS_W-1];
  end

  always_comb begin
    hit = 1'b0;
    cls = '0;
    src = SRC_UC;
    // ascending scan, last hit wins: highest non-empty class
    for (int c = 0; c < NCLS; c++) begin
      if (uc_ne[c] || mc_ne[c]) begin
        hit = 1'b1;
        cls = CLS_W'(c);
        src = (uc_ne[c] && (!mc_ne[c] || uc_first[c])) ? SRC_UC : SRC_MC;
      end
    end
  end

endmodule

// File: rtl/csq_dup_track.sv
module csq_dup_track #(
  parameter int HW    = 5,
  parameter int DUP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [HW-1:0]    set_h,
  input  logic [DUP_W-1:0] set_cnt,
  input  logic             dec,
  input  logic [HW-1:0]    dec_h,
  output logic             last
);
  localparam int NH = 1 << HW;

  logic [DUP_W-1:0] copies [NH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NH; i++) copies[i] <= '0;
    end else begin
      if (set) copies[set_h] <= set_cnt;
      if (dec && copies[dec_h] != '0) copies[dec_h] <= copies[dec_h] - DUP_W'(1);
    end
  end

  assign last = (copies[dec_h] == DUP_W'(1));

endmodule

// File: rtl/csq_sched.sv
module csq_sched
  import csq_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int N_SPECIAL = 2,
  parameter int BASE_CLS  = 2,
  parameter int SPEC_CLS  = 4,
  parameter int HANDLE_W  = 5,
  parameter int TS_W      = 8,
  parameter int MC_DEPTH  = 4,
  localparam int CLS_W    = $clog2(SPEC_CLS),
  localparam int PW       = $clog2(N_PORTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  output logic                enq_ready,
  input  logic [N_PORTS-1:0]  enq_dest,
  input  logic [CLS_W-1:0]    enq_cls,
  input  logic [HANDLE_W-1:0] enq_handle,
  input  logic                enq_mcast,
  input  logic [TS_W-1:0]     enq_ts,
  input  logic                txr_valid,
  input  logic [PW-1:0]       txr_port,
  output logic                out_valid,
  output logic                out_empty,
  output logic [HANDLE_W-1:0] out_handle,
  output logic [CLS_W-1:0]    out_cls,
  output logic                out_mcast,
  output logic                rel_valid,
  output logic [HANDLE_W-1:0] rel_handle
);
  localparam int NQ    = N_PORTS * SPEC_CLS;
  localparam int NH    = 1 << HANDLE_W;
  localparam int MCW   = HANDLE_W + TS_W;
  localparam int DUP_W = $clog2(N_PORTS + 1);

  // ---------------- per-queue state, flattened as port*SPEC_CLS + class
  logic [NQ-1:0][HANDLE_W-1:0] uc_head, uc_tail;
  logic [NQ-1:0]               uc_ne;
  logic [NQ-1:0][MCW-1:0]      mc_dout;
  logic [NQ-1:0]               mc_full, mc_empty;
  logic [NQ-1:0]               uc_push, mc_push, uc_pop, mc_pop;

  // ---------------- shared unicast storage, indexed by handle
  logic [HANDLE_W-1:0] next_ram [NH];
  logic [TS_W-1:0]     ts_ram   [NH];

  // ---------------- enqueue decode
  logic [N_PORTS-1:0][CLS_W-1:0] map_cls;
  logic                          mc_blocked;
  logic                          accept;
  logic [PW-1:0]                 uc_port;
  int                            q_enq;
  logic [DUP_W-1:0]              dest_cnt;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    localparam int LIM = cls_limit(p, N_PORTS, N_SPECIAL, BASE_CLS, SPEC_CLS);
    assign map_cls[p] = (int'(enq_cls) >= LIM) ? CLS_W'(LIM - 1) : enq_cls;
  end

  always_comb begin
    mc_blocked = 1'b0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (enq_dest[p] && mc_full[p * SPEC_CLS + int'(map_cls[p])]) mc_blocked = 1'b1;
    end
  end

  assign enq_ready = !(enq_mcast && mc_blocked);
  assign accept    = enq_valid && enq_ready;

  always_comb begin
    uc_port = '0;
    for (int p = N_PORTS - 1; p >= 0; p--) begin
      if (enq_dest[p]) uc_port = PW'(p);
    end
  end

  assign q_enq = int'(uc_port) * SPEC_CLS + int'(map_cls[uc_port]);

  always_comb begin
    dest_cnt = '0;
    for (int p = 0; p < N_PORTS; p++) dest_cnt = dest_cnt + DUP_W'(enq_dest[p]);
  end

  // link the new handle behind the current tail; a write into an empty list is unused
  always_ff @(posedge clk) begin
    if (accept && !enq_mcast) begin
      ts_ram[enq_handle] <= enq_ts;
      if (uc_ne[q_enq]) next_ram[uc_tail[q_enq]] <= enq_handle;
    end
  end

  // ---------------- dequeue select
  logic [SPEC_CLS-1:0]           sel_uc_ne, sel_mc_ne;
  logic [SPEC_CLS-1:0][TS_W-1:0] sel_uc_ts, sel_mc_ts;
  logic                          pk_hit;
  logic [CLS_W-1:0]              pk_cls;
  csq_src_e                      pk_src;
  int                            q_deq;
  logic                          do_deq;
  logic [HANDLE_W-1:0]           deq_next;
  logic [HANDLE_W-1:0]           chosen;
  logic                          mc_last;

  always_comb begin
    for (int c = 0; c < SPEC_CLS; c++) begin
      sel_uc_ne[c] = uc_ne[int'(txr_port) * SPEC_CLS + c];
      sel_mc_ne[c] = !mc_empty[int'(txr_port) * SPEC_CLS + c];
      sel_uc_ts[c] = ts_ram[uc_head[int'(txr_port) * SPEC_CLS + c]];
      sel_mc_ts[c] = mc_dout[int'(txr_port) * SPEC_CLS + c][TS_W-1:0];
    end
  end

  csq_pick #(
    .NCLS (SPEC_CLS),
    .TS_W (TS_W),
    .CLS_W(CLS_W)
  ) u_pick (
    .uc_ne(sel_uc_ne),
    .mc_ne(sel_mc_ne),
    .uc_ts(sel_uc_ts),
    .mc_ts(sel_mc_ts),
    .hit  (pk_hit),
    .cls  (pk_cls),
    .src  (pk_src)
  );

  assign q_deq    = int'(txr_port) * SPEC_CLS + int'(pk_cls);
  assign do_deq   = txr_valid && pk_hit;
  assign deq_next = next_ram[uc_head[q_deq]];
  assign chosen   = (pk_src == SRC_UC) ? uc_head[q_deq] : mc_dout[q_deq][MCW-1:TS_W];

  // ---------------- queue instances; classes a port lacks are tied off empty
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam int LIM = cls_limit(p, N_PORTS, N_SPECIAL, BASE_CLS, SPEC_CLS);
    for (genvar c = 0; c < SPEC_CLS; c++) begin : g_cls
      localparam int Q = p * SPEC_CLS + c;
      assign uc_push[Q] = accept && !enq_mcast && (int'(uc_port) == p) && enq_dest[p]
                          && (int'(map_cls[p]) == c);
      assign mc_push[Q] = accept && enq_mcast && enq_dest[p] && (int'(map_cls[p]) == c);
      assign uc_pop[Q]  = do_deq && (pk_src == SRC_UC) && (q_deq == Q);
      assign mc_pop[Q]  = do_deq && (pk_src == SRC_MC) && (q_deq == Q);
      if (c < LIM) begin : g_live
        csq_uc_ctl #(
          .HW(HANDLE_W)
        ) u_uc (
          .clk     (clk),
          .rst_n   (rst_n),
          .enq     (uc_push[Q]),
          .enq_h   (enq_handle),
          .deq     (uc_pop[Q]),
          .deq_next(deq_next),
          .head    (uc_head[Q]),
          .tail    (uc_tail[Q]),
          .nonempty(uc_ne[Q])
        );
        csq_mc_fifo #(
          .W    (MCW),
          .DEPTH(MC_DEPTH)
        ) u_mc (
          .clk  (clk),
          .rst_n(rst_n),
          .push (mc_push[Q]),
          .din  ({enq_handle, enq_ts}),
          .pop  (mc_pop[Q]),
          .dout (mc_dout[Q]),
          .full (mc_full[Q]),
          .empty(mc_empty[Q])
        );
      end else begin : g_absent
        assign uc_head[Q]  = '0;
        assign uc_tail[Q]  = '0;
        assign uc_ne[Q]    = 1'b0;
        assign mc_dout[Q]  = '0;
        assign mc_full[Q]  = 1'b0;
        assign mc_empty[Q] = 1'b1;
      end
    end
  end

  // ---------------- multicast copy accounting
  csq_dup_track #(
    .HW   (HANDLE_W),
    .DUP_W(DUP_W)
  ) u_dup (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (accept && enq_mcast),
    .set_h  (enq_handle),
    .set_cnt(dest_cnt),
    .dec    (do_deq && (pk_src == SRC_MC)),
    .dec_h  (chosen),
    .last   (mc_last)
  );

  // ---------------- registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_empty  <= 1'b0;
      out_handle <= '0;
      out_cls    <= '0;
      out_mcast  <= 1'b0;
      rel_valid  <= 1'b0;
      rel_handle <= '0;
    end else begin
      out_valid <= do_deq;
      out_empty <= txr_valid && !pk_hit;
      rel_valid <= do_deq && ((pk_src == SRC_UC) || mc_last);
      if (do_deq) begin
        out_handle <= chosen;
        out_cls    <= pk_cls;
        out_mcast  <= (pk_src == SRC_MC);
        rel_handle <= chosen;
      end
    end
  end

endmodule

// File: rtl/csq_sched_chk.sv
module csq_sched_chk #(
  parameter int N_PORTS   = 4,
  parameter int N_SPECIAL = 2,
  parameter int BASE_CLS  = 2,
  parameter int CLS_W     = 2,
  parameter int PW        = 2,
  parameter int HANDLE_W  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enq_valid,
  input logic                enq_ready,
  input logic                enq_mcast,
  input logic                txr_valid,
  input logic [PW-1:0]       txr_port,
  input logic                out_valid,
  input logic                out_empty,
  input logic [HANDLE_W-1:0] out_handle,
  input logic [CLS_W-1:0]    out_cls,
  input logic                out_mcast,
  input logic                rel_valid,
  input logic [HANDLE_W-1:0] rel_handle
);

  AST_RESULT_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    txr_valid |=> (out_valid || out_empty)); // R9

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !txr_valid |=> (!out_valid && !out_empty)); // R9

  AST_VALID_EMPTY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_empty)); // R7

  AST_UC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mcast) |-> (rel_valid && rel_handle == out_handle)); // R11

  AST_RELEASE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (out_valid && rel_handle == out_handle)); // R3

  AST_UC_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_mcast) |-> enq_ready); // R8

  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (txr_valid && int'(txr_port) < N_PORTS - N_SPECIAL)
      |=> (!out_valid || int'(out_cls) < BASE_CLS)); // R6

endmodule

bind csq_sched csq_sched_chk #(
  .N_PORTS  (N_PORTS),
  .N_SPECIAL(N_SPECIAL),
  .BASE_CLS (BASE_CLS),
  .CLS_W    (CLS_W),
  .PW       (PW),
  .HANDLE_W (HANDLE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_ready (enq_ready),
  .enq_mcast (enq_mcast),
  .txr_valid (txr_valid),
  .txr_port  (txr_port),
  .out_valid (out_valid),
  .out_empty (out_empty),
  .out_handle(out_handle),
  .out_cls   (out_cls),
  .out_mcast (out_mcast),
  .rel_valid (rel_valid),
  .rel_handle(rel_handle)
);

// File: tb/csq_sched_bench.sv
`timescale 1ns/1ps
module csq_sched_bench;
  localparam int NP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enq_valid = 1'b0;
  logic       enq_ready;
  logic [3:0] enq_dest = '0;
  logic [1:0] enq_cls = '0;
  logic [4:0] enq_handle = '0;
  logic       enq_mcast = 1'b0;
  logic [7:0] enq_ts = '0;
  logic       txr_valid = 1'b0;
  logic [1:0] txr_port = '0;
  logic       out_valid, out_empty, out_mcast, rel_valid;
  logic [4:0] out_handle, rel_handle;
  logic [1:0] out_cls;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csq_sched u_csq_sched (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_dest(enq_dest),
    .enq_cls(enq_cls), .enq_handle(enq_handle), .enq_mcast(enq_mcast), .enq_ts(enq_ts),
    .txr_valid(txr_valid), .txr_port(txr_port),
    .out_valid(out_valid), .out_empty(out_empty), .out_handle(out_handle),
    .out_cls(out_cls), .out_mcast(out_mcast), .rel_valid(rel_valid), .rel_handle(rel_handle)
  );

  task automatic check(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  // present one enqueue for one edge; expect the given ready value before the edge
  task automatic enq(input logic [3:0] dest, input int cls, input int h, input logic mc,
                     input int ts, input logic exp_rdy, input string tag);
    @(negedge clk);
    enq_valid  = 1'b1;
    enq_dest   = dest;
    enq_cls    = 2'(cls);
    enq_handle = 5'(h);
    enq_mcast  = mc;
    enq_ts     = 8'(ts);
    #1;
    if (exp_rdy !== 1'b1 || enq_ready !== 1'b1)
      check(enq_ready === exp_rdy, tag,
            $sformatf("enq_ready act=%0b exp=%0b", enq_ready, exp_rdy));
    @(posedge clk);
    #1 enq_valid = 1'b0;
  endtask

  // ready pulse for one port, then compare the result one cycle later
  task automatic pull(input int port, input logic ev, input int eh, input int ecls,
                      input logic emc, input logic erel, input string tag);
    @(negedge clk);
    txr_valid = 1'b1;
    txr_port  = 2'(port);
    @(negedge clk);
    txr_valid = 1'b0;
    if (!ev) begin
      check(out_valid === 1'b0 && out_empty === 1'b1 && rel_valid === 1'b0, tag,
            $sformatf("valid/empty/rel act=%0b/%0b/%0b exp=0/1/0", out_valid, out_empty, rel_valid));
    end else begin
      check(out_valid === 1'b1 && out_empty === 1'b0 && out_handle === 5'(eh) &&
            out_mcast === emc && (ecls < 0 || out_cls === 2'(ecls)) &&
            rel_valid === erel && (!erel || rel_handle === 5'(eh)), tag,
            $sformatf("v=%0b e=%0b h=%0d cls=%0d mc=%0b rel=%0b/%0d exp v=1 e=0 h=%0d cls=%0d mc=%0b rel=%0b",
                      out_valid, out_empty, out_handle, out_cls, out_mcast, rel_valid, rel_handle,
                      eh, ecls, emc, erel));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid === 1'b0 && out_empty === 1'b0 && rel_valid === 1'b0, "R1",
          $sformatf("idle outputs v/e/rel act=%0b/%0b/%0b exp=0/0/0", out_valid, out_empty, rel_valid));
    check(enq_ready === 1'b1, "R1", $sformatf("enq_ready act=%0b exp=1", enq_ready));
    for (int p = 0; p < NP; p++) pull(p, 1'b0, 0, 0, 1'b0, 1'b0, "R1 empty after reset");
  endtask

  task automatic t_uc_order();
    enq(4'b0001, 0, 1, 1'b0, 1, 1'b1, "R2");
    enq(4'b0001, 0, 2, 1'b0, 2, 1'b1, "R2");
    enq(4'b0001, 0, 3, 1'b0, 3, 1'b1, "R2");
    pull(0, 1'b1, 1, 0, 1'b0, 1'b1, "R2 first / R11");
    pull(0, 1'b1, 2, 0, 1'b0, 1'b1, "R2 second");
    pull(0, 1'b1, 3, 0, 1'b0, 1'b1, "R2 third");
    pull(0, 1'b0, 0, 0, 1'b0, 1'b0, "R7 drained");
  endtask

  task automatic t_mcast_dup();
    enq(4'b0101, 1, 20, 1'b1, 40, 1'b1, "R3");
    pull(0, 1'b1, 20, 1, 1'b1, 1'b0, "R3 first copy holds handle");
    pull(2, 1'b1, 20, 1, 1'b1, 1'b1, "R3 last copy releases");
    pull(0, 1'b0, 0, 0, 1'b0, 1'b0, "R3 port0 empty");
    pull(2, 1'b0, 0, 0, 1'b0, 1'b0, "R3 port2 empty");
  endtask

  task automatic t_age();
    enq(4'b0100, 0, 21, 1'b0, 10, 1'b1, "R4");
    enq(4'b0100, 0, 22, 1'b1, 5, 1'b1, "R4");
    pull(2, 1'b1, 22, 0, 1'b1, 1'b1, "R4 older multicast first");
    pull(2, 1'b1, 21, 0, 1'b0, 1'b1, "R4 then unicast");
    enq(4'b0100, 0, 23, 1'b0, 250, 1'b1, "R4");
    enq(4'b0100, 0, 24, 1'b1, 3, 1'b1, "R4");
    pull(2, 1'b1, 23, 0, 1'b0, 1'b1, "R4 wrap unicast 250 older than 3");
    pull(2, 1'b1, 24, 0, 1'b1, 1'b1, "R4 wrap multicast second");
    enq(4'b0100, 0, 25, 1'b0, 7, 1'b1, "R4");
    enq(4'b0100, 0, 26, 1'b1, 7, 1'b1, "R4");
    pull(2, 1'b1, 25, 0, 1'b0, 1'b1, "R4 tie unicast first");
    pull(2, 1'b1, 26, 0, 1'b1, 1'b1, "R4 tie multicast second");
    pull(2, 1'b0, 0, 0, 1'b0, 1'b0, "R4 drained");
  endtask

  task automatic t_prio();
    enq(4'b1000, 0, 1, 1'b0, 50, 1'b1, "R5");
    enq(4'b1000, 2, 2, 1'b0, 51, 1'b1, "R5");
    enq(4'b1000, 3, 3, 1'b0, 52, 1'b1, "R5");
    pull(3, 1'b1, 3, 3, 1'b0, 1'b1, "R5 class 3 first");
    pull(3, 1'b1, 2, 2, 1'b0, 1'b1, "R5 class 2 next");
    pull(3, 1'b1, 1, 0, 1'b0, 1'b1, "R5 class 0 last");
    pull(3, 1'b0, 0, 0, 1'b0, 1'b0, "R5 drained");
  endtask

  task automatic t_class_map();
    enq(4'b0010, 3, 5, 1'b0, 60, 1'b1, "R6");
    enq(4'b0010, 1, 6, 1'b0, 61, 1'b1, "R6");
    pull(1, 1'b1, 5, 1, 1'b0, 1'b1, "R6 class 3 folded to 1");
    pull(1, 1'b1, 6, 1, 1'b0, 1'b1, "R6 same queue order");
    pull(1, 1'b0, 0, 0, 1'b0, 1'b0, "R6 drained");
    enq(4'b1000, 3, 7, 1'b0, 62, 1'b1, "R6");
    pull(3, 1'b1, 7, 3, 1'b0, 1'b1, "R6 special port keeps class 3");
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 4; i++) enq(4'b0001, 0, 10 + i, 1'b1, 70 + i, 1'b1, "R8 fill");
    enq(4'b0001, 0, 14, 1'b1, 74, 1'b0, "R8 full multicast not ready");
    enq(4'b0011, 0, 16, 1'b1, 75, 1'b0, "R8 one full target blocks all");
    enq(4'b0001, 1, 15, 1'b0, 76, 1'b1, "R8 unicast still ready");
    pull(0, 1'b1, 15, 1, 1'b0, 1'b1, "R5 higher class before full class");
    for (int i = 0; i < 4; i++) pull(0, 1'b1, 10 + i, 0, 1'b1, 1'b1, "R8 drain");
    pull(0, 1'b0, 0, 0, 1'b0, 1'b0, "R8 refused entry never written");
    pull(1, 1'b0, 0, 0, 1'b0, 1'b0, "R8 refused multicast not on port1");
  endtask

  task automatic t_concurrent();
    enq(4'b0010, 0, 8, 1'b0, 80, 1'b1, "R10");
    @(negedge clk);
    enq_valid = 1'b1; enq_dest = 4'b0010; enq_cls = 2'd0; enq_handle = 5'd9;
    enq_mcast = 1'b0; enq_ts = 8'd81;
    txr_valid = 1'b1; txr_port = 2'd1;
    @(negedge clk);
    enq_valid = 1'b0; txr_valid = 1'b0;
    check(out_valid === 1'b1 && out_handle === 5'd8, "R10",
          $sformatf("same-cycle pull act v=%0b h=%0d exp v=1 h=8", out_valid, out_handle));
    pull(1, 1'b1, 9, 0, 1'b0, 1'b1, "R10 new head taken from incoming handle");
    pull(1, 1'b0, 0, 0, 1'b0, 1'b0, "R10 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_uc_order();
    t_mcast_dup();
    t_age();
    t_prio();
    t_class_map();
    t_backpressure();
    t_concurrent();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule